// File: doc/BRIEF.md
# Presence-Detect Byte Stream Decoder

The block sits behind whatever engine reads a memory module's presence-detect storage. That engine streams the first 128 configuration bytes into the block. Each byte comes with a valid strobe and its position number. The block does four things with the stream:

- It keeps a running 8-bit sum of the header bytes and compares it with the stored checksum byte.
- It flags any module type other than DDR SDRAM.
- It latches the address geometry, the bank count and the capability masks into registered outputs.
- It turns six core timing parameters into clock-cycle counts for the controller clock period given on an input.

Two timing encodings are converted. Three parameters are held in quarter nanoseconds and three in whole nanoseconds. A third encoding, with whole nanoseconds and tenths in separate nibbles, is decoded for two cycle-time bytes and reported in tenths of a nanosecond. A start pulse clears everything before a new module is read. Each cycle conversion runs on its own small serial divider, so bytes may arrive on every clock.

Top module: `spd_decoder`

## Requirements
- R1: `csum_done` and `csum_ok` stay 0 until the byte at position 63 is accepted. On the next clock `csum_done` becomes 1, and `csum_ok` becomes 1 exactly when that byte equals the modulo-256 sum of the bytes at positions 0 to 62.
- R2: One clock after the byte at position 2 is accepted, `type_bad` is 1 if that byte is not 0x07 and 0 if it is.
- R3: `row_bits` holds the byte at position 3, `col_bits` the byte at position 4 and `bank_cnt` the byte at position 17. Each is registered one clock after acceptance.
- R4: `bl_mask` holds the byte at position 16 and `cl_mask` the byte at position 18, unchanged. In `bl_mask`, bits 1, 2 and 3 stand for burst lengths 2, 4 and 8.
- R5: `tck_min_dt` and `tck_alt_dt` hold the bytes at positions 9 and 23 in tenths of a nanosecond, computed as upper nibble × 10 + lower nibble. For example, 0x75 gives 75.
- R6: The bytes at positions 27 (tRP), 29 (tRCD) and 28 (tRRD) are in quarter nanoseconds. For a byte q and a period p in tenths of a nanosecond, each is converted to ceil(5q / 2p) cycles. The result appears at most 16 clocks after the byte is accepted.
- R7: The bytes at positions 30 (tRAS), 41 (tRC) and 42 (tRFC) are in whole nanoseconds. For a byte n and a period p, each is converted to ceil(10n / p) cycles, with the same latency as R6.
- R8: A converted timing whose computed value would be 0 is reported as 1.
- R9: A byte whose position is 128 or above has no effect on any output and does not enter the checksum sum.
- R10: A start pulse sets every output to 0 on the next clock. A byte presented in the same cycle as start is discarded.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears accumulator and decoded state |
| byte_vld | input | 1 | Byte strobe |
| byte_idx | input | IDX_W | Position of the byte in the stream |
| byte_dat | input | 8 | Byte value |
| tck_period_dt | input | PER_W | Controller clock period, tenths of ns |
| csum_done | output | 1 | Checksum verdict valid |
| csum_ok | output | 1 | Stored checksum matched |
| type_bad | output | 1 | Module type is not DDR SDRAM |
| row_bits | output | 8 | Row address bit count |
| col_bits | output | 8 | Column address bit count |
| bank_cnt | output | 8 | Banks per device |
| bl_mask | output | 8 | Supported burst length mask |
| cl_mask | output | 8 | Supported CAS latency mask |
| tck_min_dt | output | 8 | Cycle time from position 9, tenths of ns |
| tck_alt_dt | output | 8 | Cycle time from position 23, tenths of ns |
| t_rp_cyc | output | CYC_W | Precharge time in cycles |
| t_rcd_cyc | output | CYC_W | Activate-to-column delay in cycles |
| t_rrd_cyc | output | CYC_W | Activate-to-activate delay in cycles |
| t_ras_cyc | output | CYC_W | Activate-to-precharge time in cycles |
| t_rc_cyc | output | CYC_W | Activate-to-activate, same bank, in cycles |
| t_rfc_cyc | output | CYC_W | Refresh cycle time in cycles |

## Verification
The assertions take three things for granted about the inputs:

- The clock period input is nonzero whenever a timing byte is accepted.
- The period stays steady while a stream is in progress.
- Each position below 64 is delivered at most once per stream, so the checksum verdict and the register contents are defined.

The stimulus keeps to these assumptions. It changes the period only between streams, and only just before a start pulse. It sends every low position exactly once. It adds extra beats only at positions of 128 and above. The only beat it sends at the same time as start is meant to be discarded.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int unsigned NUM_BYTES = 128;
  localparam int unsigned POS_CSUM  = 63;
  localparam int unsigned POS_TYPE  = 2;
  localparam int unsigned POS_ROW   = 3;
  localparam int unsigned POS_COL   = 4;
  localparam int unsigned POS_TCKA  = 9;
  localparam int unsigned POS_BLEN  = 16;
  localparam int unsigned POS_BANK  = 17;
  localparam int unsigned POS_CLAT  = 18;
  localparam int unsigned POS_TCKB  = 23;
  localparam logic [7:0]  TYPE_DDR  = 8'h07;

  // timing slots: rp, rcd, rrd, ras, rc, rfc
  localparam int unsigned N_TIM = 6;
  localparam int unsigned TIM_POS [N_TIM] = '{27, 29, 28, 30, 41, 42};
  // 1 = whole nanoseconds, 0 = quarter nanoseconds
  localparam logic [N_TIM-1:0] TIM_WHOLE = 6'b111000;

  function automatic logic [7:0] nib_to_dt(input logic [7:0] b);
    return 8'(b[7:4] * 4'd10) + {4'd0, b[3:0]};
  endfunction
endpackage

// File: rtl/spd_ceil_div.sv
module spd_ceil_div #(
  parameter int NUM_W = 12,
  parameter int DEN_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo_out
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q, rem_n;
  logic [NUM_W-1:0] quo_q, quo_n, num_adj;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, take;
  logic [DEN_W:0]   shifted;
  logic [DEN_W+1:0] diff;

  always_comb begin
    num_adj = num + NUM_W'(den) - NUM_W'(1);
    shifted = {rem_q, quo_q[NUM_W-1]};
    diff    = {1'b0, shifted} - {2'b00, den_q};
    take    = !diff[DEN_W+1];
    rem_n   = take ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
    quo_n   = {quo_q[NUM_W-2:0], take};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rem_q <= '0; quo_q <= '0; den_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; quo_out <= '0;
    end else if (go) begin
      rem_q <= '0;
      quo_q <= num_adj;
      den_q <= den;
      cnt_q <= CNT_W'(NUM_W);
      run_q <= 1'b1;
    end else if (run_q) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        run_q   <= 1'b0;
        quo_out <= (quo_n == '0) ? NUM_W'(1) : quo_n;
      end
    end
  end

  AST_MIN_ONE: assert property (@(posedge clk) disable iff (rst)
    (run_q && !go && !clr && cnt_q == CNT_W'(1)) |=> (quo_out != '0)); // R8
  AST_DEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    go |-> (den != '0)); // R6
endmodule

// File: rtl/spd_field_regs.sv
module spd_field_regs
  import spd_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             vld,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       dat,
  output logic             csum_done,
  output logic             csum_ok,
  output logic             type_bad,
  output logic [7:0]       row_bits,
  output logic [7:0]       col_bits,
  output logic [7:0]       bank_cnt,
  output logic [7:0]       bl_mask,
  output logic [7:0]       cl_mask,
  output logic [7:0]       tck_min_dt,
  output logic [7:0]       tck_alt_dt
);
  int unsigned idx_i;
  logic        take;
  logic [7:0]  sum_q;

  always_comb begin
    idx_i = 32'(idx);
    take  = vld && (idx_i < NUM_BYTES);
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      sum_q <= '0; csum_done <= 1'b0; csum_ok <= 1'b0; type_bad <= 1'b0;
      row_bits <= '0; col_bits <= '0; bank_cnt <= '0;
      bl_mask <= '0; cl_mask <= '0; tck_min_dt <= '0; tck_alt_dt <= '0;
    end else if (take) begin
      if (idx_i < POS_CSUM) sum_q <= sum_q + dat;
      if (idx_i == POS_CSUM) begin
        csum_done <= 1'b1;
        csum_ok   <= (sum_q == dat);
      end
      if (idx_i == POS_TYPE) type_bad   <= (dat != TYPE_DDR);
      if (idx_i == POS_ROW)  row_bits   <= dat;
      if (idx_i == POS_COL)  col_bits   <= dat;
      if (idx_i == POS_BANK) bank_cnt   <= dat;
      if (idx_i == POS_BLEN) bl_mask    <= dat;
      if (idx_i == POS_CLAT) cl_mask    <= dat;
      if (idx_i == POS_TCKA) tck_min_dt <= nib_to_dt(dat);
      if (idx_i == POS_TCKB) tck_alt_dt <= nib_to_dt(dat);
    end
  end

  AST_CSUM_ORDER: assert property (@(posedge clk) disable iff (rst)
    csum_ok |-> csum_done); // R1
  AST_TYPE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (vld && !start && idx_i == POS_TYPE) |=> (type_bad == ($past(dat) != TYPE_DDR))); // R2
endmodule

// File: rtl/spd_decoder.sv
module spd_decoder
  import spd_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int PER_W = 8,
  parameter int CYC_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             byte_vld,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic [7:0]       byte_dat,
  input  logic [PER_W-1:0] tck_period_dt,
  output logic             csum_done,
  output logic             csum_ok,
  output logic             type_bad,
  output logic [7:0]       row_bits,
  output logic [7:0]       col_bits,
  output logic [7:0]       bank_cnt,
  output logic [7:0]       bl_mask,
  output logic [7:0]       cl_mask,
  output logic [7:0]       tck_min_dt,
  output logic [7:0]       tck_alt_dt,
  output logic [CYC_W-1:0] t_rp_cyc,
  output logic [CYC_W-1:0] t_rcd_cyc,
  output logic [CYC_W-1:0] t_rrd_cyc,
  output logic [CYC_W-1:0] t_ras_cyc,
  output logic [CYC_W-1:0] t_rc_cyc,
  output logic [CYC_W-1:0] t_rfc_cyc
);
  localparam int DEN_W = PER_W + 1;

  logic [CYC_W-1:0] cyc [N_TIM];

  spd_field_regs #(.IDX_W(IDX_W)) u_fields (
    .clk(clk), .rst(rst), .start(start), .vld(byte_vld), .idx(byte_idx), .dat(byte_dat),
    .csum_done(csum_done), .csum_ok(csum_ok), .type_bad(type_bad),
    .row_bits(row_bits), .col_bits(col_bits), .bank_cnt(bank_cnt),
    .bl_mask(bl_mask), .cl_mask(cl_mask),
    .tck_min_dt(tck_min_dt), .tck_alt_dt(tck_alt_dt)
  );

  for (genvar g = 0; g < N_TIM; g++) begin : g_tim
    logic             go;
    logic [CYC_W-1:0] num;
    logic [DEN_W-1:0] den;
    always_comb begin
      go = byte_vld && !start && (32'(byte_idx) == TIM_POS[g]);
      if (TIM_WHOLE[g]) begin
        num = CYC_W'(byte_dat) * CYC_W'(10);
        den = DEN_W'(tck_period_dt);
      end else begin
        num = CYC_W'(byte_dat) * CYC_W'(5);
        den = {tck_period_dt, 1'b0};
      end
    end
    spd_ceil_div #(.NUM_W(CYC_W), .DEN_W(DEN_W)) u_div (
      .clk(clk), .rst(rst), .clr(start), .go(go),
      .num(num), .den(den), .quo_out(cyc[g])
    );
  end

  assign t_rp_cyc  = cyc[0];
  assign t_rcd_cyc = cyc[1];
  assign t_rrd_cyc = cyc[2];
  assign t_ras_cyc = cyc[3];
  assign t_rc_cyc  = cyc[4];
  assign t_rfc_cyc = cyc[5];

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(start) |-> (!csum_done && row_bits == '0 && t_rp_cyc == '0 && t_rfc_cyc == '0)); // R10
endmodule

// File: tb/sim_spd_decoder.sv
`timescale 1ns/1ps
module sim_spd_decoder;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0, vld = 1'b0;
  logic [7:0] idx = '0, dat = '0, per = 8'd75;
  logic csum_done, csum_ok, type_bad;
  logic [7:0] row_bits, col_bits, bank_cnt, bl_mask, cl_mask, tck_min_dt, tck_alt_dt;
  logic [11:0] t_rp, t_rcd, t_rrd, t_ras, t_rc, t_rfc;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  spd_decoder u0 (
    .clk(clk), .rst(rst), .start(start), .byte_vld(vld), .byte_idx(idx), .byte_dat(dat),
    .tck_period_dt(per), .csum_done(csum_done), .csum_ok(csum_ok), .type_bad(type_bad),
    .row_bits(row_bits), .col_bits(col_bits), .bank_cnt(bank_cnt), .bl_mask(bl_mask),
    .cl_mask(cl_mask), .tck_min_dt(tck_min_dt), .tck_alt_dt(tck_alt_dt),
    .t_rp_cyc(t_rp), .t_rcd_cyc(t_rcd), .t_rrd_cyc(t_rrd), .t_ras_cyc(t_ras),
    .t_rc_cyc(t_rc), .t_rfc_cyc(t_rfc)
  );

  // {corrupt, type, period, rp, rcd, rrd, ras, rc, rfc}
  localparam logic [64:0] VEC [5] = '{
    {1'b0, 8'h07, 8'd75,  8'h50, 8'h50, 8'h3C, 8'h2D, 8'h41, 8'h4B},
    {1'b0, 8'h07, 8'd100, 8'h50, 8'h50, 8'h3C, 8'h32, 8'h46, 8'h50},
    {1'b0, 8'h07, 8'd1,   8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF},
    {1'b1, 8'h06, 8'd200, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    {1'b0, 8'h07, 8'd255, 8'hFF, 8'h11, 8'h01, 8'hFF, 8'h01, 8'h80}
  };

  function automatic logic [7:0] img(int i, logic [64:0] v);
    case (i)
      2: return v[63:56];
      3: return 8'h0D;
      4: return 8'h0A;
      9: return 8'h75;
      16: return 8'h0E;
      17: return 8'h04;
      18: return 8'h0C;
      23: return 8'hA0;
      27: return v[47:40];
      29: return v[39:32];
      28: return v[31:24];
      30: return v[23:16];
      41: return v[15:8];
      42: return v[7:0];
      default: return 8'((i * 37 + 11) & 255);
    endcase
  endfunction

  function automatic int ceil_cyc(int num, int den);
    int r;
    r = (num + den - 1) / den;
    return (r < 1) ? 1 : r;
  endfunction

  function automatic int nib(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  task automatic chk(string name, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", name, got, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic stream(logic [64:0] v, bit inject);
    logic [7:0] sum;
    sum = '0;
    for (int i = 0; i < 128; i++) begin
      if (i == 63) chk("R1 verdict before checksum byte", int'(csum_done), 0);
      vld = 1'b1; idx = 8'(i);
      if (i < 63) begin dat = img(i, v); sum = sum + dat; end
      else if (i == 63) dat = sum ^ {7'd0, v[64]};
      else dat = img(i, v);
      @(negedge clk);
      if (inject && i < 64) begin
        idx = 8'(i) | 8'h80; dat = ~img(i, v) + 8'h01;
        @(negedge clk);
      end
    end
    vld = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic check_all(logic [64:0] v, string tag);
    int p;
    p = int'(v[55:48]);
    chk({tag, " R1 done"}, int'(csum_done), 1);
    chk({tag, " R1 ok"}, int'(csum_ok), v[64] ? 0 : 1);
    chk({tag, " R2 type"}, int'(type_bad), (v[63:56] != 8'h07) ? 1 : 0);
    chk({tag, " R3 row"}, int'(row_bits), 13);
    chk({tag, " R3 col"}, int'(col_bits), 10);
    chk({tag, " R3 banks"}, int'(bank_cnt), 4);
    chk({tag, " R4 bl"}, int'(bl_mask), 8'h0E);
    chk({tag, " R4 cl"}, int'(cl_mask), 8'h0C);
    chk({tag, " R5 tck9"}, int'(tck_min_dt), nib(8'h75));
    chk({tag, " R5 tck23"}, int'(tck_alt_dt), nib(8'hA0));
    chk({tag, " R6 R8 rp"}, int'(t_rp), ceil_cyc(5 * int'(v[47:40]), 2 * p));
    chk({tag, " R6 R8 rcd"}, int'(t_rcd), ceil_cyc(5 * int'(v[39:32]), 2 * p));
    chk({tag, " R6 R8 rrd"}, int'(t_rrd), ceil_cyc(5 * int'(v[31:24]), 2 * p));
    chk({tag, " R7 R8 ras"}, int'(t_ras), ceil_cyc(10 * int'(v[23:16]), p));
    chk({tag, " R7 R8 rc"}, int'(t_rc), ceil_cyc(10 * int'(v[15:8]), p));
    chk({tag, " R7 R8 rfc"}, int'(t_rfc), ceil_cyc(10 * int'(v[7:0]), p));
  endtask

  task automatic check_zero(string tag);
    chk({tag, " done"}, int'(csum_done), 0);
    chk({tag, " ok"}, int'(csum_ok), 0);
    chk({tag, " type"}, int'(type_bad), 0);
    chk({tag, " row"}, int'(row_bits), 0);
    chk({tag, " masks"}, int'(bl_mask) + int'(cl_mask) + int'(bank_cnt) + int'(col_bits), 0);
    chk({tag, " tck"}, int'(tck_min_dt) + int'(tck_alt_dt), 0);
    chk({tag, " cycles"}, int'(t_rp) + int'(t_rcd) + int'(t_rrd) + int'(t_ras)
                          + int'(t_rc) + int'(t_rfc), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_zero("R11 reset");

    for (int k = 0; k < 5; k++) begin
      per = VEC[k][55:48];
      pulse_start();
      stream(VEC[k], 1'b0);
      check_all(VEC[k], $sformatf("vec%0d", k));
    end

    // R9: beats at positions >= 128 interleaved with a stream
    per = VEC[0][55:48];
    pulse_start();
    stream(VEC[0], 1'b1);
    check_all(VEC[0], "R9 high-index");

    // R10: start clears; a byte presented with start is dropped
    start = 1'b1; vld = 1'b1; idx = 8'd3; dat = 8'h1F;
    @(negedge clk);
    start = 1'b0; vld = 1'b0;
    @(negedge clk);
    check_zero("R10 start");
    repeat (20) @(negedge clk);
    chk("R10 no late conversion", int'(t_rp), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule